// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers configuration accesses for one PCI type-0 function through a byte-wide port. Each access carries a function number, an 8-bit register offset, a write strobe and a write byte. Read data comes back combinationally from the same offset. The block holds the fixed identification bytes and a two-bit command register. It also holds one I/O base address register with 32-byte granularity and an interrupt line byte. A strap input supplies the slot number, which the block reports in the revision position.

The decoded I/O base and the I/O-enable bit leave the block as plain outputs for a neighbouring I/O window decoder. Writes update the stored state on the rising clock edge, and both outputs follow in the same cycle. Reset is asynchronous and active low. Reset leaves I/O decoding switched off and the base at zero.

Top module: `cfg_header_target`

## Requirements
- R1: Only function number 0 is served. With any other function number the read data is 0xFF and writes change no state.
- R2: Offsets 0x00, 0x01, 0x02 and 0x03 read 0x1A, 0x07, 0x0B and 0xAB. Offsets 0x2C to 0x2F read the same four bytes in the same order.
- R3: A write to offset 0x04 stores only bits 1:0 of the data, and offset 0x04 reads back the stored value with bits 7:2 zero. `io_enable` equals stored bit 0 from the edge that takes the write.
- R4: Offsets 0x05, 0x06, 0x07, 0x0A and 0x0B read 0x00 after reset, and writes to them leave that value unchanged.
- R5: Offset 0x08 reads the value on the `slot_id` strap.
- R6: A write to offset 0x10 keeps only data bits 7:5. A read of 0x10 returns those bits with bits 4:1 zero and bit 0 set to 1, which marks an I/O space BAR.
- R7: Offset 0x11 is fully writable and reads back what was written. `io_base` is {byte 0x11, stored bits 7:5 of byte 0x10, 5'b00000}.
- R8: Offset 0x3C is a fully writable interrupt line byte. Offset 0x3D always reads 0x01, which selects INTA, and ignores writes.
- R9: Every other offset with function 0 reads 0x00, and writes there change no stored register.
- R10: Reset clears the command register, the BAR and the interrupt line byte, so `io_enable` is 0, `io_base` is 0 and offset 0x10 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_id | input | 8 | Slot number strap, reported at offset 0x08 |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Register offset of the access |
| cfg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Read data byte for the current function and offset |
| io_enable | output | 1 | I/O decoding enable, command bit 0 |
| io_base | output | 16 | Decoded I/O base, low five bits zero |

## Verification
The bench builds the block with its default identification parameters and a two-bit command field. With these values the exact bytes 0x1A, 0x07, 0x0B and 0xAB can be checked at both the primary and the mirrored offsets. It ties the slot strap to 5 so that the revision position shows a value that no reset state could produce. It writes all-ones bytes into the masked fields so that every discarded bit is exposed, then asserts reset in the middle of the run to confirm that the exported base and enable return to zero.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] OFS_CMD_LO  = 8'h04;
  localparam logic [7:0] OFS_CMD_HI  = 8'h05;
  localparam logic [7:0] OFS_STS_LO  = 8'h06;
  localparam logic [7:0] OFS_STS_HI  = 8'h07;
  localparam logic [7:0] OFS_REV     = 8'h08;
  localparam logic [7:0] OFS_CLS_LO  = 8'h0A;
  localparam logic [7:0] OFS_CLS_HI  = 8'h0B;
  localparam logic [7:0] OFS_BAR_B0  = 8'h10;
  localparam logic [7:0] OFS_BAR_B1  = 8'h11;
  localparam logic [7:0] OFS_INT_LN  = 8'h3C;
  localparam logic [7:0] OFS_INT_PN  = 8'h3D;
  localparam logic [7:0] INTA_CODE   = 8'h01;

  // Picks one byte of the identification word: {device, vendor}, little endian.
  function automatic logic [7:0] id_byte(input logic [15:0] vid,
                                         input logic [15:0] did,
                                         input logic [1:0]  idx);
    logic [31:0] word;
    word = {did, vid};
    return word[idx*8 +: 8];
  endfunction

  // True for the identification block and its mirror in the subsystem slot.
  function automatic logic is_id_ofs(input logic [7:0] ofs);
    return (ofs[7:2] == 6'h00) || (ofs[7:2] == 6'h0B);
  endfunction

  // BAR low byte as seen by software: kept bits on top, I/O marker in bit 0.
  function automatic logic [7:0] bar_lo_view(input logic [2:0] kept);
    return {kept, 4'b0000, 1'b1};
  endfunction

  // Full decoded base from the stored BAR fields.
  function automatic logic [15:0] base_of(input logic [7:0] hi,
                                          input logic [2:0] lo_kept);
    return {hi, lo_kept, 5'b00000};
  endfunction

endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfg_hdr_pkg::*;
#(
  parameter int FUNC_W = 3
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [7:0]        ofs,
  input  logic              wr,
  output logic              fn_hit,
  output logic              wr_cmd,
  output logic              wr_bar_b0,
  output logic              wr_bar_b1,
  output logic              wr_int_ln
);

  always_comb begin
    fn_hit    = (func == '0);
    wr_cmd    = wr && fn_hit && (ofs == OFS_CMD_LO);
    wr_bar_b0 = wr && fn_hit && (ofs == OFS_BAR_B0);
    wr_bar_b1 = wr && fn_hit && (ofs == OFS_BAR_B1);
    wr_int_ln = wr && fn_hit && (ofs == OFS_INT_LN);
  end

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_hdr_pkg::*;
#(
  parameter int CMD_W  = 2,
  parameter int KEEP_W = 3,
  parameter int RSV_N  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_bar_b0,
  input  logic              wr_bar_b1,
  input  logic              wr_int_ln,
  input  logic [7:0]        wdata,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [KEEP_W-1:0] bar_b0_q,
  output logic [7:0]        bar_b1_q,
  output logic [7:0]        int_ln_q,
  output logic [7:0]        rsv_q [RSV_N]
);

  localparam int KEEP_LSB = BYTE_W - KEEP_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      bar_b0_q <= '0;
      bar_b1_q <= '0;
      int_ln_q <= '0;
    end else begin
      if (wr_cmd)    cmd_q    <= wdata[CMD_W-1:0];
      if (wr_bar_b0) bar_b0_q <= wdata[BYTE_W-1:KEEP_LSB];
      if (wr_bar_b1) bar_b1_q <= wdata;
      if (wr_int_ln) int_ln_q <= wdata;
    end
  end

  // Read-only stored bytes: cleared by reset, never loaded from the port.
  for (genvar g = 0; g < RSV_N; g++) begin : g_rsv
    logic [7:0] held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else        held <= held;
    end
    assign rsv_q[g] = held;
  end

  assert_cmd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> cmd_q == $past(wdata[CMD_W-1:0]));

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(cmd_q));

  assert_bar_hi_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bar_b1 |=> bar_b1_q == $past(wdata));

  assert_int_ln_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_int_ln |=> $stable(int_ln_q));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h071A,
  parameter logic [15:0] DEVICE_ID = 16'hAB0B,
  parameter int          CMD_W     = 2,
  parameter int          KEEP_W    = 3,
  parameter int          RSV_N     = 5
) (
  input  logic              fn_hit,
  input  logic [7:0]        ofs,
  input  logic [7:0]        slot,
  input  logic [CMD_W-1:0]  cmd_q,
  input  logic [KEEP_W-1:0] bar_b0_q,
  input  logic [7:0]        bar_b1_q,
  input  logic [7:0]        int_ln_q,
  input  logic [7:0]        rsv_q [RSV_N],
  output logic [7:0]        rdata
);

  logic [7:0] cmd_view;

  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_W-1:0] = cmd_q;
  end

  always_comb begin
    rdata = 8'h00;
    if (!fn_hit) begin
      rdata = 8'hFF;
    end else if (is_id_ofs(ofs)) begin
      rdata = id_byte(VENDOR_ID, DEVICE_ID, ofs[1:0]);
    end else begin
      unique case (ofs)
        OFS_CMD_LO: rdata = cmd_view;
        OFS_CMD_HI: rdata = rsv_q[0];
        OFS_STS_LO: rdata = rsv_q[1];
        OFS_STS_HI: rdata = rsv_q[2];
        OFS_REV:    rdata = slot;
        OFS_CLS_LO: rdata = rsv_q[3];
        OFS_CLS_HI: rdata = rsv_q[4];
        OFS_BAR_B0: rdata = bar_lo_view(bar_b0_q);
        OFS_BAR_B1: rdata = bar_b1_q;
        OFS_INT_LN: rdata = int_ln_q;
        OFS_INT_PN: rdata = INTA_CODE;
        default:    rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/cfg_header_target.sv
module cfg_header_target
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h071A,
  parameter logic [15:0] DEVICE_ID = 16'hAB0B,
  parameter int          FUNC_W    = 3,
  parameter int          CMD_W     = 2,
  parameter int          ALIGN_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        slot_id,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              io_enable,
  output logic [15:0]       io_base
);

  localparam int KEEP_W = BYTE_W - ALIGN_W;
  localparam int RSV_N  = 5;

  logic              fn_hit;
  logic              wr_cmd, wr_bar_b0, wr_bar_b1, wr_int_ln;
  logic [CMD_W-1:0]  cmd_q;
  logic [KEEP_W-1:0] bar_b0_q;
  logic [7:0]        bar_b1_q;
  logic [7:0]        int_ln_q;
  logic [7:0]        rsv_q [RSV_N];

  cfg_wr_decode #(.FUNC_W(FUNC_W)) u_dec (
    .func      (cfg_func),
    .ofs       (cfg_addr),
    .wr        (cfg_wr),
    .fn_hit    (fn_hit),
    .wr_cmd    (wr_cmd),
    .wr_bar_b0 (wr_bar_b0),
    .wr_bar_b1 (wr_bar_b1),
    .wr_int_ln (wr_int_ln)
  );

  cfg_reg_file #(.CMD_W(CMD_W), .KEEP_W(KEEP_W), .RSV_N(RSV_N)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmd    (wr_cmd),
    .wr_bar_b0 (wr_bar_b0),
    .wr_bar_b1 (wr_bar_b1),
    .wr_int_ln (wr_int_ln),
    .wdata     (cfg_wdata),
    .cmd_q     (cmd_q),
    .bar_b0_q  (bar_b0_q),
    .bar_b1_q  (bar_b1_q),
    .int_ln_q  (int_ln_q),
    .rsv_q     (rsv_q)
  );

  cfg_read_mux #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .CMD_W     (CMD_W),
    .KEEP_W    (KEEP_W),
    .RSV_N     (RSV_N)
  ) u_mux (
    .fn_hit   (fn_hit),
    .ofs      (cfg_addr),
    .slot     (slot_id),
    .cmd_q    (cmd_q),
    .bar_b0_q (bar_b0_q),
    .bar_b1_q (bar_b1_q),
    .int_ln_q (int_ln_q),
    .rsv_q    (rsv_q),
    .rdata    (cfg_rdata)
  );

  assign io_enable = cmd_q[0];
  assign io_base   = base_of(bar_b1_q, bar_b0_q);

  assert_func_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func != '0) |-> cfg_rdata == 8'hFF);

  assert_int_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func == '0 && cfg_addr == OFS_INT_PN) |-> cfg_rdata == INTA_CODE);

  assert_enable_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_func == '0 && cfg_addr == OFS_CMD_LO) |=> io_enable == $past(cfg_wdata[0]));

  assert_base_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_func == '0 && cfg_addr == OFS_BAR_B1) |=> io_base[15:8] == $past(cfg_wdata));

endmodule

// File: tb/cfg_header_target_tb.sv
module cfg_header_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  // {write, func[2:0], offset[7:0], data/expected[7:0], requirement[3:0]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 8'h1A, 4'd2},   // R2
    {1'b0, 3'd0, 8'h01, 8'h07, 4'd2},
    {1'b0, 3'd0, 8'h02, 8'h0B, 4'd2},
    {1'b0, 3'd0, 8'h03, 8'hAB, 4'd2},
    {1'b0, 3'd0, 8'h2C, 8'h1A, 4'd2},
    {1'b0, 3'd0, 8'h2D, 8'h07, 4'd2},
    {1'b0, 3'd0, 8'h2E, 8'h0B, 4'd2},
    {1'b0, 3'd0, 8'h2F, 8'hAB, 4'd2},
    {1'b0, 3'd0, 8'h08, 8'h05, 4'd5},   // R5
    {1'b0, 3'd0, 8'h3D, 8'h01, 4'd8},   // R8
    {1'b0, 3'd0, 8'h10, 8'h01, 4'd10},  // R10
    {1'b0, 3'd0, 8'h04, 8'h00, 4'd10},
    {1'b1, 3'd0, 8'h04, 8'hFF, 4'd3},   // R3
    {1'b0, 3'd0, 8'h04, 8'h03, 4'd3},
    {1'b1, 3'd0, 8'h10, 8'hFF, 4'd6},   // R6
    {1'b0, 3'd0, 8'h10, 8'hE1, 4'd6},
    {1'b1, 3'd0, 8'h11, 8'hC3, 4'd7},   // R7
    {1'b0, 3'd0, 8'h11, 8'hC3, 4'd7},
    {1'b1, 3'd0, 8'h3C, 8'h5A, 4'd8},
    {1'b0, 3'd0, 8'h3C, 8'h5A, 4'd8},
    {1'b1, 3'd0, 8'h06, 8'hFF, 4'd4},   // R4
    {1'b0, 3'd0, 8'h06, 8'h00, 4'd4},
    {1'b1, 3'd0, 8'h0A, 8'h77, 4'd4},
    {1'b0, 3'd0, 8'h0A, 8'h00, 4'd4},
    {1'b1, 3'd0, 8'h40, 8'h12, 4'd9},   // R9
    {1'b0, 3'd0, 8'h40, 8'h00, 4'd9},
    {1'b0, 3'd0, 8'h3C, 8'h5A, 4'd9},
    {1'b1, 3'd1, 8'h04, 8'h00, 4'd1},   // R1
    {1'b0, 3'd1, 8'h04, 8'hFF, 4'd1},
    {1'b0, 3'd0, 8'h04, 8'h03, 4'd1},
    {1'b0, 3'd0, 8'h3E, 8'h00, 4'd9},
    {1'b1, 3'd0, 8'h3D, 8'h00, 4'd8},
    {1'b0, 3'd0, 8'h3D, 8'h01, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  slot_id = 8'h05;
  logic [2:0]  cfg_func = '0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        io_enable;
  logic [15:0] io_base;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_header_target u_dut (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .cfg_func(cfg_func),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .io_enable(io_enable), .io_base(io_base)
  );

  // Bench-side view of the base: high byte, then the three kept bits.
  function automatic logic [15:0] exp_base(input logic [7:0] hi, input logic [7:0] lo_wr);
    return (16'(hi) << 8) | 16'(lo_wr & 8'hE0);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] f, input logic [7:0] a,
                          input logic [7:0] e, input string req);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_wr = 1'b0;
    #1;
    check(req, {8'h00, cfg_rdata}, {8'h00, e});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #2;
    check("R10 io_enable at reset", {15'd0, io_enable}, 16'h0000);
    check("R10 io_base at reset", io_base, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23])
        wr_cfg(VEC[i][22:20], VEC[i][19:12], VEC[i][11:4]);
      else
        rd_check(VEC[i][22:20], VEC[i][19:12], VEC[i][11:4],
                 $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end

    // R7 / R3: exported base and enable after the table writes.
    #1;
    check("R7 io_base", io_base, exp_base(8'hC3, 8'hFF));
    check("R3 io_enable set", {15'd0, io_enable}, 16'h0001);

    // R3: clearing bit 0 while bit 1 stays set drops the enable on that edge.
    wr_cfg(3'd0, 8'h04, 8'hFE);
    #1;
    check("R3 io_enable cleared", {15'd0, io_enable}, 16'h0000);
    rd_check(3'd0, 8'h04, 8'h02, "R3 command readback");

    // R6: low bits written to the BAR byte are dropped, I/O marker stays.
    wr_cfg(3'd0, 8'h10, 8'h1F);
    rd_check(3'd0, 8'h10, 8'h01, "R6 low bits dropped");
    #1;
    check("R6 base low byte", io_base, exp_base(8'hC3, 8'h1F));

    // R1: a write on another function leaves the BAR high byte alone.
    wr_cfg(3'd7, 8'h11, 8'h00);
    rd_check(3'd0, 8'h11, 8'hC3, "R1 other function write ignored");

    // R10: reset in mid-run clears command, BAR and interrupt line.
    wr_cfg(3'd0, 8'h04, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 io_enable after reset", {15'd0, io_enable}, 16'h0000);
    check("R10 io_base after reset", io_base, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    rd_check(3'd0, 8'h3C, 8'h00, "R10 interrupt line cleared");
    rd_check(3'd0, 8'h10, 8'h01, "R10 BAR low cleared");
    rd_check(3'd0, 8'h04, 8'h00, "R10 command cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule